// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block holds the programming state of an I/O interrupt controller. A 32-bit memory-mapped bus can reach only two locations. One is a selector register and the other is a data window. Software first writes the selector with the number of an internal register, then reads or writes that register through the window. Behind the window sit an identification register, a read-only version register that reports how many lines the table holds, an arbitration identification register, and a redirection table with one 64-bit entry per interrupt line.

Each table entry is seen through the window as two 32-bit words at neighbouring selector values. The even value reaches the low word and the odd value reaches the high word. When software writes a word, the bits that carry no field are stored as zero. The current mask, vector, delivery mode, destination mode and destination of every entry are driven in parallel to the dispatch logic. All lines come out of reset masked.

Top module: `irq_route_regs`

## Requirements
- R1: Byte offset 0 is the selector and byte offset 16 is the data window, and both can be read and written. Read data appears on `rdata` with `rvalid` high exactly one clock after the read request is sampled, and `rvalid` is low in every other cycle.
- R2: An access acts only when `be` is 4'hF and the offset is 0 or 16. Any other write changes nothing, and any other read returns 0.
- R3: The selector stores only bits 7:0 of a write and reads back as {24'h0, selector}.
- R4: Selector value 0x00 reaches the ID register. A write stores `wdata[27:24]`, and a read returns the ID in bits 27:24 with every other bit zero. After reset the ID holds the parameter `RESET_ID`.
- R5: Selector value 0x01 reaches the version register. It reads (NUM_LINES−1) in bits 23:16, the code `VERSION` (default 8'h11) in bits 7:0 and zero elsewhere. Writes to it have no effect.
- R6: Selector value 0x02 reaches the arbitration ID. It stores `wdata[27:24]`, reads back in bits 27:24 and resets to `RESET_ID`.
- R7: Entry i has its low word at selector 0x10+2i and its high word at 0x11+2i. The low word holds the vector in 7:0, the delivery mode in 10:8, the destination mode in 11 and the mask in 16. The high word holds the destination in 31:24, which is bit 63:56 of the entry.
- R8: Writing a low word stores `wdata & 32'h0001_0FFF`. Writing a high word stores `wdata & 32'hFF00_0000`.
- R9: After reset every entry reads 32'h0001_0000 in its low word and 0 in its high word, so every `ent_mask` bit is 1 and every other field is 0.
- R10: A selector value that names no register (0x03 to 0x0F, and 0x10+2·NUM_LINES to 0xFF) reads as 0 through the window. A write to such a value changes no register.
- R11: The entry field outputs change only in the clock after an accepted write through the window, and they show the new value from that clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Bus access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset of the access |
| be | input | 4 | Byte enables; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| ent_mask | output | NUM_LINES | Mask bit per line |
| ent_vector | output | 8*NUM_LINES | Vector per line, line i in bits 8i+7:8i |
| ent_dlv | output | 3*NUM_LINES | Delivery mode per line |
| ent_dmode | output | NUM_LINES | Destination mode per line |
| ent_dest | output | 8*NUM_LINES | Destination per line |

## Verification
A write takes effect at the rising edge that samples it. The stored register and the entry field outputs are therefore due one clock after the request, and read data is due with `rvalid` one clock after the read request. The bench drives every access on a falling edge and holds it across one rising edge. It then compares the ports on the next falling edge, which is exactly when those registered values have become valid and cannot race the edge. Near-exhaustive sweeps read all 256 selector values against an arithmetic shadow model after reset and after each of two write patterns over the whole table.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

   localparam int VEC_W  = 8;
   localparam int DLV_W  = 3;
   localparam int DEST_W = 8;

   // stored bits of each half of an entry
   localparam logic [31:0] LO_KEEP = 32'h0001_0FFF;
   localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

   localparam logic [7:0] SEL_ID   = 8'h00;
   localparam logic [7:0] SEL_VER  = 8'h01;
   localparam logic [7:0] SEL_ARB  = 8'h02;
   localparam logic [7:0] TBL_BASE = 8'h10;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              mask;
      logic              dmode;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vector;
   } irqr_entry_t;

   function automatic logic [31:0] pack_lo(input irqr_entry_t e);
      pack_lo = {15'd0, e.mask, 4'd0, e.dmode, e.dlv, e.vector};
   endfunction

   function automatic logic [31:0] pack_hi(input irqr_entry_t e);
      pack_hi = {e.dest, 24'd0};
   endfunction

endpackage

// File: rtl/irqr_bus_decode.sv
module irqr_bus_decode #(
   parameter int ADDR_W  = 5,
   parameter int WIN_OFS = 16
) (
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output logic              sel_wr,
   output logic              win_wr,
   output logic              sel_rd,
   output logic              win_rd,
   output logic              any_rd
);

   localparam logic [ADDR_W-1:0] SEL_ADDR = '0;
   localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(WIN_OFS);

   logic full_word;
   logic hit_sel;
   logic hit_win;

   assign full_word = (be == 4'hF);
   assign hit_sel   = req && full_word && (addr == SEL_ADDR);
   assign hit_win   = req && full_word && (addr == WIN_ADDR);

   assign sel_wr = hit_sel &&  we;
   assign win_wr = hit_win &&  we;
   assign sel_rd = hit_sel && !we;
   assign win_rd = hit_win && !we;
   assign any_rd = req && !we;

endmodule

// File: rtl/irqr_id_regs.sv
module irqr_id_regs #(
   parameter int              ID_W      = 4,
   parameter int              NUM_LINES = 24,
   parameter logic [ID_W-1:0] RESET_ID  = '0,
   parameter logic [7:0]      VERSION   = 8'h11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            win_wr,
   input  logic [7:0]      index,
   input  logic [ID_W-1:0] id_in,
   output logic            rd_hit,
   output logic [31:0]     rd_word
);
   import irqr_pkg::*;

   localparam logic [7:0] LAST_LINE = 8'(NUM_LINES - 1);
   localparam int         PAD_W     = 8 - ID_W;

   logic [ID_W-1:0] id_q;
   logic [ID_W-1:0] arb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q  <= RESET_ID;
         arb_q <= RESET_ID;
      end else if (win_wr) begin
         if (index == SEL_ID)  id_q  <= id_in;
         if (index == SEL_ARB) arb_q <= id_in;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            rd_hit  = 1'b1;
            rd_word = '0;
            case (index)
               SEL_ID:  rd_word = {{PAD_W{1'b0}}, id_q, 24'd0};
               SEL_VER: rd_word = {8'd0, LAST_LINE, 8'd0, VERSION};
               SEL_ARB: rd_word = {{PAD_W{1'b0}}, arb_q, 24'd0};
               default: rd_hit  = 1'b0;
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            rd_hit  = 1'b1;
            rd_word = '0;
            case (index)
               SEL_ID:  rd_word = {id_q, 24'd0};
               SEL_VER: rd_word = {8'd0, LAST_LINE, 8'd0, VERSION};
               SEL_ARB: rd_word = {arb_q, 24'd0};
               default: rd_hit  = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/irqr_redir_entry.sv
module irqr_redir_entry (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_lo,
   input  logic                  wr_hi,
   input  irqr_pkg::irqr_entry_t cand,
   output irqr_pkg::irqr_entry_t ent
);
   import irqr_pkg::*;

   irqr_entry_t ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q      <= '0;
         ent_q.mask <= 1'b1;
      end else begin
         if (wr_lo) begin
            ent_q.vector <= cand.vector;
            ent_q.dlv    <= cand.dlv;
            ent_q.dmode  <= cand.dmode;
            ent_q.mask   <= cand.mask;
         end
         if (wr_hi) begin
            ent_q.dest <= cand.dest;
         end
      end
   end

   assign ent = ent_q;

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
   parameter int         NUM_LINES = 24,
   parameter int         ID_W      = 4,
   parameter int         ADDR_W    = 5,
   parameter logic [3:0] RESET_ID  = 4'h0,
   parameter logic [7:0] VERSION   = 8'h11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [3:0]             be,
   input  logic [31:0]            wdata,
   output logic [31:0]            rdata,
   output logic                   rvalid,
   output logic [NUM_LINES-1:0]   ent_mask,
   output logic [8*NUM_LINES-1:0] ent_vector,
   output logic [3*NUM_LINES-1:0] ent_dlv,
   output logic [NUM_LINES-1:0]   ent_dmode,
   output logic [8*NUM_LINES-1:0] ent_dest
);
   import irqr_pkg::*;

   localparam int         WIN_OFS = 16;
   localparam int         SLOT_W  = $clog2(NUM_LINES);
   localparam logic [7:0] TBL_LEN = 8'(2 * NUM_LINES);

   generate
      if (NUM_LINES < 2 || NUM_LINES > 120) begin : g_bad_lines
         $error("NUM_LINES must lie in 2..120 to fit the 8-bit selector");
      end
      if (ID_W != 4) begin : g_bad_id
         $error("ID_W must be 4 to match RESET_ID");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach the window at byte offset 16");
      end
   endgenerate

   logic sel_wr, win_wr, sel_rd, win_rd, any_rd;

   irqr_bus_decode #(
      .ADDR_W (ADDR_W),
      .WIN_OFS(WIN_OFS)
   ) u_dec (
      .req   (req),
      .we    (we),
      .addr  (addr),
      .be    (be),
      .sel_wr(sel_wr),
      .win_wr(win_wr),
      .sel_rd(sel_rd),
      .win_rd(win_rd),
      .any_rd(any_rd)
   );

   // selector register
   logic [7:0] index_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      index_q <= '0;
      else if (sel_wr) index_q <= wdata[7:0];
   end

   // ID, version and arbitration registers
   logic        id_hit;
   logic [31:0] id_word;

   irqr_id_regs #(
      .ID_W     (ID_W),
      .NUM_LINES(NUM_LINES),
      .RESET_ID (RESET_ID),
      .VERSION  (VERSION)
   ) u_id (
      .clk    (clk),
      .rst_n  (rst_n),
      .win_wr (win_wr),
      .index  (index_q),
      .id_in  (wdata[24 +: ID_W]),
      .rd_hit (id_hit),
      .rd_word(id_word)
   );

   // write candidate, reserved bits dropped by construction of the struct
   irqr_entry_t cand;
   always_comb begin
      cand.vector = wdata[7:0];
      cand.dlv    = wdata[10:8];
      cand.dmode  = wdata[11];
      cand.mask   = wdata[16];
      cand.dest   = wdata[31:24];
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[23:17], wdata[15:12]};

   // redirection table
   irqr_entry_t ent_q [NUM_LINES];

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_ent
         localparam logic [7:0] LO_SEL = 8'(16 + 2 * g);
         localparam logic [7:0] HI_SEL = 8'(17 + 2 * g);

         irqr_redir_entry u_ent (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_lo(win_wr && (index_q == LO_SEL)),
            .wr_hi(win_wr && (index_q == HI_SEL)),
            .cand (cand),
            .ent  (ent_q[g])
         );

         assign ent_mask[g]         = ent_q[g].mask;
         assign ent_vector[8*g +: 8] = ent_q[g].vector;
         assign ent_dlv[3*g +: 3]   = ent_q[g].dlv;
         assign ent_dmode[g]        = ent_q[g].dmode;
         assign ent_dest[8*g +: 8]   = ent_q[g].dest;
      end
   endgenerate

   // window read mux
   logic [7:0]        rel;
   logic              tbl_hit;
   logic [SLOT_W-1:0] slot;
   logic [31:0]       win_word;
   irqr_entry_t       ent_sel;

   assign rel     = index_q - TBL_BASE;
   assign tbl_hit = (index_q >= TBL_BASE) && (rel < TBL_LEN);
   assign slot    = rel[SLOT_W:1];

   always_comb begin
      ent_sel  = '0;
      win_word = '0;
      if (id_hit) begin
         win_word = id_word;
      end else if (tbl_hit) begin
         ent_sel  = ent_q[slot];
         win_word = rel[0] ? pack_hi(ent_sel) : pack_lo(ent_sel);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= any_rd;
         if (any_rd) begin
            if (sel_rd)      rdata <= {24'd0, index_q};
            else if (win_rd) rdata <= win_word;
            else             rdata <= '0;
         end
      end
   end

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
   parameter int         NUM_LINES = 24,
   parameter int         ADDR_W    = 5,
   parameter logic [7:0] VERSION   = 8'h11
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req,
   input logic                   we,
   input logic [ADDR_W-1:0]      addr,
   input logic [3:0]             be,
   input logic [31:0]            rdata,
   input logic                   rvalid,
   input logic [7:0]             index_q,
   input logic [NUM_LINES-1:0]   ent_mask,
   input logic [8*NUM_LINES-1:0] ent_vector,
   input logic [3*NUM_LINES-1:0] ent_dlv,
   input logic [NUM_LINES-1:0]   ent_dmode,
   input logic [8*NUM_LINES-1:0] ent_dest
);

   localparam logic [ADDR_W-1:0] A_SEL = '0;
   localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(16);

   logic rd_req, win_wr_acc;
   assign rd_req     = req && !we;
   assign win_wr_acc = req && we && (be == 4'hF) && (addr == A_WIN);

   // R1
   rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rvalid);

   // R1
   no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rvalid);

   // R2
   partial_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && be != 4'hF) |=> ($stable(index_q) && $stable(ent_mask)
         && $stable(ent_vector) && $stable(ent_dest)));

   // R2
   bad_offset_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && addr != A_SEL && addr != A_WIN) |=> (rdata == 32'd0));

   // R3
   selector_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && be == 4'hF && addr == A_SEL) |=> (rdata[31:8] == 24'd0));

   // R5
   version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && be == 4'hF && addr == A_WIN && index_q == 8'h01)
      |=> (rdata == {8'd0, 8'(NUM_LINES - 1), 8'd0, VERSION}));

   // R11
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_wr_acc |=> ($stable(ent_mask) && $stable(ent_vector) && $stable(ent_dlv)
         && $stable(ent_dmode) && $stable(ent_dest)));

endmodule

bind irq_route_regs irqr_chk #(
   .NUM_LINES(NUM_LINES),
   .ADDR_W   (ADDR_W),
   .VERSION  (VERSION)
) u_chk (.*);

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;

   localparam int         N      = 24;
   localparam int         AW     = 5;
   localparam logic [3:0] RST_ID = 4'hA;
   localparam logic [31:0] LO_K  = 32'h0001_0FFF;
   localparam logic [31:0] HI_K  = 32'hFF00_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [3:0]    be = 4'hF;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rvalid;
   logic [N-1:0]   ent_mask;
   logic [8*N-1:0] ent_vector;
   logic [3*N-1:0] ent_dlv;
   logic [N-1:0]   ent_dmode;
   logic [8*N-1:0] ent_dest;

   irq_route_regs #(.NUM_LINES(N), .ADDR_W(AW), .RESET_ID(RST_ID)) u_irq_route_regs (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .ent_mask(ent_mask),
      .ent_vector(ent_vector), .ent_dlv(ent_dlv), .ent_dmode(ent_dmode),
      .ent_dest(ent_dest)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // shadow model
   logic [31:0] m_lo [N];
   logic [31:0] m_hi [N];
   logic [3:0]  m_id, m_arb;
   logic [7:0]  m_sel;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] ix);
      int r;
      r = int'(ix) - 16;
      if (ix == 8'h00)      exp_read = {4'd0, m_id, 24'd0};
      else if (ix == 8'h01) exp_read = {8'd0, 8'(N - 1), 8'd0, 8'h11};
      else if (ix == 8'h02) exp_read = {4'd0, m_arb, 24'd0};
      else if (r >= 0 && r < 2 * N) exp_read = r[0] ? m_hi[r / 2] : m_lo[r / 2];
      else exp_read = 32'd0;
   endfunction

   function automatic string tag_of(input logic [7:0] ix);
      if (ix == 8'h00)      tag_of = "R4";
      else if (ix == 8'h01) tag_of = "R5";
      else if (ix == 8'h02) tag_of = "R6";
      else if (ix >= 8'h10 && int'(ix) < 16 + 2 * N) tag_of = "R7";
      else tag_of = "R10";
   endfunction

   // every task starts and ends just after a falling edge
   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
      req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0; be = 4'hF;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic [3:0] b, output logic [31:0] d);
      req = 1'b1; we = 1'b0; addr = a; be = b;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; be = 4'hF;
      d = rdata;
      check("R1 rvalid on read", 32'(rvalid), 32'd1);
   endtask

   task automatic reg_wr(input logic [7:0] ix, input logic [31:0] d);
      bus_wr(5'd0, {24'd0, ix}, 4'hF);
      m_sel = ix;
      bus_wr(5'd16, d, 4'hF);
   endtask

   task automatic reg_rd(input logic [7:0] ix, output logic [31:0] d);
      bus_wr(5'd0, {24'd0, ix}, 4'hF);
      m_sel = ix;
      bus_rd(5'd16, 4'hF, d);
   endtask

   task automatic check_ports(input string tag);
      for (int i = 0; i < N; i++) begin
         check({tag, " mask"},   32'(ent_mask[i]),        32'(m_lo[i][16]));
         check({tag, " vector"}, 32'(ent_vector[8*i +: 8]), 32'(m_lo[i][7:0]));
         check({tag, " dlv"},    32'(ent_dlv[3*i +: 3]),  32'(m_lo[i][10:8]));
         check({tag, " dmode"},  32'(ent_dmode[i]),       32'(m_lo[i][11]));
         check({tag, " dest"},   32'(ent_dest[8*i +: 8]),  32'(m_hi[i][31:24]));
      end
   endtask

   task automatic sweep_all();
      logic [31:0] d;
      for (int ix = 0; ix < 256; ix++) begin
         reg_rd(8'(ix), d);
         check(tag_of(8'(ix)), d, exp_read(8'(ix)));
      end
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] p;
      for (int i = 0; i < N; i++) begin
         m_lo[i] = 32'h0001_0000;
         m_hi[i] = 32'd0;
      end
      m_id = RST_ID; m_arb = RST_ID; m_sel = 8'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state at the ports and through the window
      check("R9 reset masks", 32'(ent_mask), 32'(N'('1)));
      check("R9 reset vectors", 32'(ent_vector[31:0]), 32'd0);
      check("R1 rvalid idle", 32'(rvalid), 32'd0);
      bus_rd(5'd0, 4'hF, d);
      check("R3 reset selector", d, 32'd0);
      sweep_all();

      // R3 selector keeps low byte
      bus_wr(5'd0, 32'hABCD_1234, 4'hF);
      bus_rd(5'd0, 4'hF, d);
      check("R3 selector low byte", d, 32'h0000_0034);

      // R4 / R6 ID and arbitration ID
      reg_wr(8'h00, 32'hF5FF_FFFF); m_id = 4'h5;
      reg_rd(8'h00, d);
      check("R4 id write", d, 32'h0500_0000);
      reg_wr(8'h02, 32'h0C00_0000); m_arb = 4'hC;
      reg_rd(8'h02, d);
      check("R6 arb write", d, 32'h0C00_0000);
      reg_rd(8'h00, d);
      check("R6 arb write leaves id", d, 32'h0500_0000);

      // R5 version read-only
      reg_wr(8'h01, 32'hFFFF_FFFF);
      reg_rd(8'h01, d);
      check("R5 version after write", d, {8'd0, 8'(N - 1), 8'd0, 8'h11});

      // R7 R8 R11 table, two patterns
      for (int k = 0; k < 2; k++) begin
         for (int i = 0; i < N; i++) begin
            p = (32'(i) * 32'h9E37_79B9) ^ (k == 0 ? 32'hFFFF_F0F0 : 32'h00FE_0F0F);
            reg_wr(8'(16 + 2 * i), p);
            m_lo[i] = p & LO_K;
            check("R11 lo field visible", 32'(ent_vector[8*i +: 8]), 32'(p[7:0]));
            check("R11 mask visible", 32'(ent_mask[i]), 32'(p[16]));
            p = ~p ^ (32'(i) << 26);
            reg_wr(8'(17 + 2 * i), p);
            m_hi[i] = p & HI_K;
            check("R11 dest visible", 32'(ent_dest[8*i +: 8]), 32'(p[31:24]));
         end
         check_ports("R7");
         sweep_all();
         reg_rd(8'h10, d);
         check("R8 low reserved zero", d & ~LO_K, 32'd0);
      end

      // R10 undefined writes
      reg_wr(8'(16 + 2 * N), 32'hFFFF_FFFF);
      reg_wr(8'h0F, 32'hFFFF_FFFF);
      reg_wr(8'h03, 32'hFFFF_FFFF);
      reg_wr(8'hFF, 32'hFFFF_FFFF);
      check_ports("R10 undefined write");
      sweep_all();

      // R2 partial and misplaced accesses
      bus_wr(5'd0, 32'h0000_0010, 4'hF); m_sel = 8'h10;
      bus_wr(5'd16, 32'h0000_0000, 4'h3);
      check_ports("R2 partial window write");
      bus_wr(5'd0, 32'h0000_0055, 4'h1);
      bus_rd(5'd0, 4'hF, d);
      check("R2 partial selector write", d, 32'h0000_0010);
      bus_wr(5'd4, 32'h0000_0000, 4'hF);
      bus_wr(5'd20, 32'h0000_0000, 4'hF);
      check_ports("R2 bad offset write");
      bus_rd(5'd0, 4'hF, d);
      check("R2 bad offset write selector", d, 32'h0000_0010);
      bus_rd(5'd8, 4'hF, d);
      check("R2 bad offset read", d, 32'd0);
      bus_rd(5'd16, 4'hF, d);
      check("R1 window read", d, m_lo[0]);
      bus_rd(5'd16, 4'h7, d);
      check("R2 partial read", d, 32'd0);

      // R9 second reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         m_lo[i] = 32'h0001_0000;
         m_hi[i] = 32'd0;
      end
      m_id = RST_ID; m_arb = RST_ID;
      check_ports("R9 re-reset");
      reg_rd(8'h02, d);
      check("R9 arb after reset", d, {4'd0, RST_ID, 24'd0});

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule